// File: doc/BRIEF.md
# DVI Pin-Pattern Stream Generator

This block turns a progressive raster into a stream of 8-bit pin words, one word per serial bit time. Each word carries the red, green and blue TMDS lanes and the TMDS clock lane, with each lane driven as a true/complement pair. The block runs on the bit-time clock, which is nominally 250 MHz, or ten bit times for each 25 MHz pixel. Every pin word can go straight to a group of eight output pins.

A raster sequencer counts bit times, pixels and lines. From the line counter it decides whether the current line is an active picture line, a plain blanking line or a blanking line that carries vertical sync. On active pixels it loads the three 10-bit symbols supplied by upstream encoders. On every other pixel it loads sync-dependent control symbols. Each loaded symbol is then shifted out LSB first over the ten bit times of its pixel.

A strobe and the pixel coordinates are exported so that an upstream source can see which pixel is about to be taken. The source can prepare that pixel's symbols during the previous pixel period. The default timing is 640x480 at about 60 Hz (800 x 525 totals).

Top module: `dvi_pin_stream`

## Requirements
- R1: Pin word bit order, MSB to LSB, is red true, red complement, green true, green complement, blue true, blue complement, clock true, clock complement. In every bit time each complement pin is the inverse of its true pin.
- R2: Each pixel lasts exactly ten bit times. Its symbol is loaded on the first bit time of the pixel (the cycle in which `pix_take_o` is high) and appears on the lane LSB first, starting in the following cycle.
- R3: The clock lane sends 1 during the first five bit times of each symbol period and 0 during the last five.
- R4: `pix_x_o` counts pixels from 0 to H_ACT+H_FP+H_SW+H_BP-1 and holds across the ten bit times of a pixel. `pix_y_o` counts lines from 0 to V_ACT+V_FP+V_SW+V_BP-1. Both wrap to 0.
- R5: For an active pixel (x < H_ACT and y < V_ACT), the red, green and blue lanes carry the symbols present on `red_sym_i`, `grn_sym_i` and `blu_sym_i` at the take cycle. Symbol input values in any other cycle have no effect.
- R6: On every non-active pixel the symbol inputs are ignored. Red and green send control symbol 1101010100 (bit 9 down to bit 0).
- R7: Horizontal sync is low when H_ACT+H_FP <= x < H_ACT+H_FP+H_SW and high otherwise. The blue lane's control symbol, indexed by the {vertical, horizontal} sync levels, is: 00 gives 1101010100, 01 gives 0010101011, 10 gives 0101010100, 11 gives 1010101011.
- R8: Vertical sync is low on lines V_ACT+V_FP <= y < V_ACT+V_FP+V_SW. It is high on all other lines, and it is never low on an active line.
- R9: `pix_take_o` is high for exactly one cycle in ten. `pix_act_o` is high exactly when the pixel at (`pix_x_o`, `pix_y_o`) is active.
- R10: While `rst_ni` is low, and asynchronously on its assertion, the counters are 0, `pix_take_o` is 1 and the pin word is 01010101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-time clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| red_sym_i | input | 10 | Red encoded symbol for the pixel being taken |
| grn_sym_i | input | 10 | Green encoded symbol for the pixel being taken |
| blu_sym_i | input | 10 | Blue encoded symbol for the pixel being taken |
| pin_o | output | 8 | Packed true/complement pin word for this bit time |
| pix_take_o | output | 1 | Symbols are sampled at the end of this cycle |
| pix_act_o | output | 1 | Current pixel is in the active picture |
| pix_x_o | output | $clog2(H total) | Pixel index within the line |
| pix_y_o | output | $clog2(V total) | Line index within the frame |

## Verification
The bench drives different junk on the symbol inputs in every non-take cycle and during all blanking, so a design that samples one cycle late or passes data through during blanking shows corrupted lane bits. It crosses every horizontal and vertical boundary, including the sync windows and the frame wrap. A wrong window comparison, or a blue control symbol looked up with the sync levels swapped, puts a wrong symbol on exactly those pixels. It checks bit order within every symbol, so an MSB-first shifter or a mis-phased clock lane fails on the first pixel. It also applies an asynchronous reset mid-frame and requires a clean restart from pixel zero.

// File: rtl/dvi_stream_pkg.sv
package dvi_stream_pkg;
  localparam int SYM_W = 10;
  localparam int NLANE = 4;  // 3=red 2=green 1=blue 0=clock

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {
    LK_ACTIVE = 2'd0,
    LK_BLANK  = 2'd1,
    LK_VSYNC  = 2'd2
  } line_kind_e;

  localparam sym_t CLK_PAT = sym_t'((1 << (SYM_W / 2)) - 1);

  function automatic sym_t ctrl_sym(input logic vs_lvl, input logic hs_lvl);
    case ({vs_lvl, hs_lvl})
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction
endpackage

// File: rtl/dvi_raster_seq.sv
module dvi_raster_seq
  import dvi_stream_pkg::*;
#(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int V_BP  = 33,
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int XW = $clog2(H_TOT),
  localparam int YW = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          take_o,
  output logic          act_o,
  output logic          hsync_n_o,
  output line_kind_e    kind_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);
  localparam int BW = $clog2(SYM_W);
  localparam logic [BW-1:0] B_LAST = BW'(SYM_W - 1);
  localparam logic [XW-1:0] H_LAST = XW'(H_TOT - 1);
  localparam logic [XW-1:0] H_ACT_X = XW'(H_ACT);
  localparam logic [XW-1:0] HS_BEG = XW'(H_ACT + H_FP);
  localparam logic [XW-1:0] HS_END = XW'(H_ACT + H_FP + H_SW);
  localparam logic [YW-1:0] V_LAST = YW'(V_TOT - 1);
  localparam logic [YW-1:0] V_ACT_Y = YW'(V_ACT);
  localparam logic [YW-1:0] VS_BEG = YW'(V_ACT + V_FP);
  localparam logic [YW-1:0] VS_END = YW'(V_ACT + V_FP + V_SW);

  logic [BW-1:0] bit_q;
  logic [XW-1:0] h_q;
  logic [YW-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      h_q   <= '0;
      v_q   <= '0;
    end else if (bit_q == B_LAST) begin
      bit_q <= '0;
      if (h_q == H_LAST) begin
        h_q <= '0;
        v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  always_comb begin
    if (v_q < V_ACT_Y)                        kind_o = LK_ACTIVE;
    else if (v_q >= VS_BEG && v_q < VS_END)   kind_o = LK_VSYNC;
    else                                      kind_o = LK_BLANK;
  end

  assign take_o    = (bit_q == '0);
  assign hsync_n_o = !(h_q >= HS_BEG && h_q < HS_END);
  assign act_o     = (kind_o == LK_ACTIVE) && (h_q < H_ACT_X);
  assign x_o       = h_q;
  assign y_o       = v_q;
endmodule

// File: rtl/dvi_sym_select.sv
module dvi_sym_select
  import dvi_stream_pkg::*;
(
  input  line_kind_e             kind_i,
  input  logic                   act_i,
  input  logic                   hsync_n_i,
  input  sym_t                   red_i,
  input  sym_t                   grn_i,
  input  sym_t                   blu_i,
  output logic [NLANE-1:0][SYM_W-1:0] lane_sym_o
);
  logic vsync_n;
  sym_t idle_sym;
  sym_t sync_sym;

  assign vsync_n  = (kind_i != LK_VSYNC);
  assign idle_sym = ctrl_sym(1'b0, 1'b0);
  assign sync_sym = ctrl_sym(vsync_n, hsync_n_i);

  always_comb begin
    lane_sym_o[0] = CLK_PAT;
    if (act_i) begin
      lane_sym_o[3] = red_i;
      lane_sym_o[2] = grn_i;
      lane_sym_o[1] = blu_i;
    end else begin
      lane_sym_o[3] = idle_sym;
      lane_sym_o[2] = idle_sym;
      lane_sym_o[1] = sync_sym;
    end
  end
endmodule

// File: rtl/dvi_lane_shift.sv
module dvi_lane_shift
  import dvi_stream_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  sym_t sym_i,
  output logic bit_o
);
  sym_t sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= sym_i;
    else             sh_q <= {1'b0, sh_q[SYM_W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/dvi_pin_stream.sv
module dvi_pin_stream
  import dvi_stream_pkg::*;
#(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int V_BP  = 33,
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int XW = $clog2(H_TOT),
  localparam int YW = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [9:0]    red_sym_i,
  input  logic [9:0]    grn_sym_i,
  input  logic [9:0]    blu_sym_i,
  output logic [7:0]    pin_o,
  output logic          pix_take_o,
  output logic          pix_act_o,
  output logic [XW-1:0] pix_x_o,
  output logic [YW-1:0] pix_y_o
);
  line_kind_e kind;
  logic       hsync_n;
  logic [NLANE-1:0][SYM_W-1:0] lane_sym;
  logic [NLANE-1:0]            lane_bit;

  dvi_raster_seq #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_o    (pix_take_o),
    .act_o     (pix_act_o),
    .hsync_n_o (hsync_n),
    .kind_o    (kind),
    .x_o       (pix_x_o),
    .y_o       (pix_y_o)
  );

  dvi_sym_select u_sel (
    .kind_i     (kind),
    .act_i      (pix_act_o),
    .hsync_n_i  (hsync_n),
    .red_i      (red_sym_i),
    .grn_i      (grn_sym_i),
    .blu_i      (blu_sym_i),
    .lane_sym_o (lane_sym)
  );

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    dvi_lane_shift u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (pix_take_o),
      .sym_i  (lane_sym[i]),
      .bit_o  (lane_bit[i])
    );
    assign pin_o[2*i+1] = lane_bit[i];
    assign pin_o[2*i]   = ~lane_bit[i];
  end
endmodule

// File: rtl/dvi_pin_stream_chk.sv
module dvi_pin_stream_chk #(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int V_BP  = 33,
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int XW = $clog2(H_TOT),
  localparam int YW = $clog2(V_TOT)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    pin_o,
  input logic          pix_take_o,
  input logic          pix_act_o,
  input logic [XW-1:0] pix_x_o,
  input logic [YW-1:0] pix_y_o
);
  a_r1_pair_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o[7] != pin_o[6]) && (pin_o[5] != pin_o[4]) &&
    (pin_o[3] != pin_o[2]) && (pin_o[1] != pin_o[0]));

  a_r3_clk_low_at_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_take_o |-> !pin_o[1]);

  a_r3_clk_high_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_take_o |=> pin_o[1]);

  a_r9_take_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_take_o |=> !pix_take_o);

  a_r4_x_stable_mid_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_take_o |=> (pix_take_o || $stable(pix_x_o)));

  a_r4_y_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(pix_y_o) < V_TOT) && (int'(pix_x_o) < H_TOT));

  a_r9_act_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_act_o |-> (int'(pix_x_o) < H_ACT) && (int'(pix_y_o) < V_ACT));
endmodule

bind dvi_pin_stream dvi_pin_stream_chk #(
  .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
  .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pin_o      (pin_o),
  .pix_take_o (pix_take_o),
  .pix_act_o  (pix_act_o),
  .pix_x_o    (pix_x_o),
  .pix_y_o    (pix_y_o)
);

// File: tb/dvi_pin_stream_bench.sv
module dvi_pin_stream_bench;
  localparam int CLK_PERIOD = 4;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HT * VT * 10;
  localparam int XW = $clog2(HT);
  localparam int YW = $clog2(VT);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [9:0]    red_sym_i = '0, grn_sym_i = '0, blu_sym_i = '0;
  logic [7:0]    pin_o;
  logic          pix_take_o, pix_act_o;
  logic [XW-1:0] pix_x_o;
  logic [YW-1:0] pix_y_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dvi_pin_stream #(
    .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB)
  ) u_dvi_pin_stream (
    .clk_i, .rst_ni, .red_sym_i, .grn_sym_i, .blu_sym_i,
    .pin_o, .pix_take_o, .pix_act_o, .pix_x_o, .pix_y_o
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] dsym(input int p, input int ch);
    return 10'((p * 37) + (ch * 211) + ((p >> 3) * 13) + 5);
  endfunction

  function automatic logic [9:0] ctrl(input bit vs, input bit hs);
    case ({vs, hs})
      2'b00: return 10'b1101010100;
      2'b01: return 10'b0010101011;
      2'b10: return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  // state after k edges since reset release
  task automatic check_state(input int k);
    int p, j, h, v, cp, ch, cv;
    bit act, hs_n, vs_n;
    bit [3:0] eb;
    logic [7:0] ew;
    string tag;
    cp = k / 10;
    ch = cp % HT;
    cv = (cp / HT) % VT;
    check("R4 pixel x", int'(pix_x_o), ch);
    check("R4 line y", int'(pix_y_o), cv);
    check("R9 take strobe", int'(pix_take_o), int'(k % 10 == 0));
    check("R9 active flag", int'(pix_act_o), int'(ch < HA && cv < VA));
    if (k == 0) begin
      check("R10 first word", int'(pin_o), 8'h55);
      return;
    end
    p = (k - 1) / 10;
    j = (k - 1) % 10;
    h = p % HT;
    v = (p / HT) % VT;
    act  = (h < HA) && (v < VA);
    hs_n = !(h >= HA + HF && h < HA + HF + HS);
    vs_n = !(v >= VA + VF && v < VA + VF + VS);
    if (act) begin
      eb[3] = dsym(p, 0)[j];
      eb[2] = dsym(p, 1)[j];
      eb[1] = dsym(p, 2)[j];
      tag = "R2 R5 active data";
    end else begin
      eb[3] = ctrl(1'b0, 1'b0)[j];
      eb[2] = ctrl(1'b0, 1'b0)[j];
      eb[1] = ctrl(vs_n, hs_n)[j];
      if (!vs_n)      tag = "R8 vsync control";
      else if (!hs_n) tag = "R7 hsync control";
      else            tag = "R6 blank control";
    end
    eb[0] = (j < 5);
    check({tag, " red"}, int'(pin_o[7]), int'(eb[3]));
    check({tag, " green"}, int'(pin_o[5]), int'(eb[2]));
    check({tag, " blue"}, int'(pin_o[3]), int'(eb[1]));
    check("R3 clock lane", int'(pin_o[1]), int'(eb[0]));
    ew = {eb[3], ~eb[3], eb[2], ~eb[2], eb[1], ~eb[1], eb[0], ~eb[0]};
    check("R1 pin word", int'(pin_o), int'(ew));
  endtask

  task automatic drive(input int k);
    int p;
    p = k / 10;
    if (k % 10 == 0) begin
      red_sym_i = dsym(p, 0);
      grn_sym_i = dsym(p, 1);
      blu_sym_i = dsym(p, 2);
    end else begin
      red_sym_i = ~dsym(p + k, 0);
      grn_sym_i = ~dsym(p + k, 1);
      blu_sym_i = ~dsym(p + k, 2);
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk_i);
      check_state(k);
      drive(k);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset word", int'(pin_o), 8'h55);
    check("R10 reset x", int'(pix_x_o), 0);
    check("R10 reset y", int'(pix_y_o), 0);
    check("R10 reset take", int'(pix_take_o), 1);
    rst_ni = 1'b1;
    run(2 * FRAME + 37);
    @(posedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    check("R10 async reset word", int'(pin_o), 8'h55);
    check("R10 async reset x", int'(pix_x_o), 0);
    check("R10 async reset y", int'(pix_y_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(FRAME + 20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule